// File: doc/BRIEF.md
# Floating-point issue, dispatch and in-order retire controller

This block sits between a host CPU and a set of floating-point execution units. The CPU issues one instruction per cycle through a valid/ready handshake. Each instruction names a target unit, a destination register and two source registers. The instruction waits in a read stage until no older instruction that is still in flight writes one of its sources, and until a reorder slot is free. It is then registered into the first execute stage. That step commits it, and a dispatch strobe fires on the chosen unit.

The units fall into two groups. The lower-numbered units produce single-precision results and the higher-numbered units produce double-precision results. Each unit returns its result a fixed number of cycles after its dispatch strobe. Results can therefore finish in any order. A small reorder buffer, indexed by a tag that travels with each unit's fixed-latency pipeline, holds finished results until every older one has left. Write-back to the register file then happens strictly in issue order, one result per cycle.

The arithmetic itself is outside the block. The controller only tracks tags, destinations and result words.

Top module: `fpco_issue_ctrl`

## Requirements
- R1: During reset and afterwards until a new instruction is accepted, no dispatch strobe and no write-back is raised. `iss_ready` is high in the first cycle after reset is released.
- R2: An instruction is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. While the read-stage instruction cannot leave, `iss_ready` is low and the held instruction does not change. Independent instructions are accepted and dispatched on consecutive cycles.
- R3: At most one bit of `disp_valid` is high in any cycle, and that bit is the unit index. With no stall, an instruction accepted on edge k shows its strobe, together with its source indices on `disp_src_a`/`disp_src_b`, after edge k+1.
- R4: Units 0 to NSP-1 are single precision, with latency 1+2*i for unit i. Units NSP to NSP+NDP-1 are double precision, with latency 2+2*j for the j-th of them. With the defaults, units 0, 1, 2 and 3 have latencies 1, 3, 2 and 4. Unit u returns `res_valid[u]` with its result on `res_data[64*u+63:64*u]` exactly its latency in cycles after its dispatch strobe.
- R5: The read-stage instruction stalls while either of its sources overlaps the destination of any instruction that has been dispatched but not yet written back. It dispatches in the cycle after that producer's write-back.
- R6: When either the in-flight instruction or the read-stage instruction is double precision, the overlap test compares register indices with bit 0 ignored, so that the even/odd pair counts as one register. Otherwise it compares all bits.
- R7: Write-backs appear in issue order, even when a younger instruction finishes first. A result that is waiting is written back in the cycle after the older one.
- R8: No more than DEPTH (default 4) instructions are between dispatch and write-back. When DEPTH are in flight, the read stage stalls. With the defaults, five independent back-to-back instructions to unit 3 dispatch at cycle offsets 0, 1, 2, 3 and 7.
- R9: `wb_dst` is the instruction's destination. `wb_dp` is 1 for a double-precision unit. `wb_data` carries all 64 result bits for double precision. For single precision it carries only the low 32 bits, with bits 63:32 zero, whatever the unit drove there.
- R10: An instruction that meets no stall is written back L+2 cycles after its dispatch strobe, where L is its unit's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Host offers an instruction |
| iss_ready | output | 1 | Read stage can take an instruction this cycle |
| iss_unit | input | UW (2) | Target functional unit index |
| iss_dst | input | RW (5) | Destination register index |
| iss_src_a | input | RW (5) | First source register index |
| iss_src_b | input | RW (5) | Second source register index |
| disp_valid | output | NUNIT (4) | One-hot dispatch strobe, one bit per unit |
| disp_src_a | output | RW (5) | First source of the dispatched instruction |
| disp_src_b | output | RW (5) | Second source of the dispatched instruction |
| res_valid | input | NUNIT (4) | Per-unit result strobe |
| res_data | input | NUNIT*DW (256) | Per-unit result words, unit u in slice u |
| wb_valid | output | 1 | Register-file write enable |
| wb_dst | output | RW (5) | Register-file write index |
| wb_dp | output | 1 | Write covers a double-precision pair |
| wb_data | output | DW (64) | Write data |

## Verification
The checker assumes that every unit honours its fixed latency: `res_valid` for a unit must match the output of the controller's tag pipeline for that unit in every cycle. The bench guarantees this with a behavioural unit model. On each dispatch strobe the model schedules the reply exactly the unit's latency later and derives the result word from the dispatched sources. It also writes non-zero upper bits for single-precision units. The host side is assumed to hold `iss_valid` and its fields steady until acceptance, which the bench's issue task does.

// File: rtl/fpco_pkg.sv
package fpco_pkg;

  typedef enum logic {
    GRP_SP = 1'b0,
    GRP_DP = 1'b1
  } fpco_grp_e;

  // Latency of unit u: single-precision units first, then double-precision.
  function automatic int unit_lat(input int u, input int nsp, input int step);
    if (u < nsp) return 1 + u * step;
    return 2 + (u - nsp) * step;
  endfunction

  function automatic fpco_grp_e unit_grp(input int u, input int nsp);
    return (u < nsp) ? GRP_SP : GRP_DP;
  endfunction

endpackage

// File: rtl/fpco_lat_line.sv
module fpco_lat_line #(
  parameter int LAT = 1,
  parameter int TW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [TW-1:0] in_tag,
  output logic          out_v,
  output logic [TW-1:0] out_tag
);

  logic [LAT-1:0]         v_q;
  logic [LAT-1:0][TW-1:0] t_q;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= in_v;
        t_q <= in_tag;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[LAT-2:0], in_v};
        t_q <= {t_q[LAT-2:0], in_tag};
      end
    end
  endgenerate

  assign out_v   = v_q[LAT-1];
  assign out_tag = t_q[LAT-1];

endmodule

// File: rtl/fpco_hazard.sv
module fpco_hazard #(
  parameter int DEPTH = 4,
  parameter int RW    = 5
) (
  input  logic [DEPTH-1:0]         ent_v,
  input  logic [DEPTH-1:0]         ent_dp,
  input  logic [DEPTH-1:0][RW-1:0] ent_dst,
  input  logic [RW-1:0]            src_a,
  input  logic [RW-1:0]            src_b,
  input  logic                     rd_dp,
  output logic                     hazard
);

  function automatic logic overlap(input logic [RW-1:0] x, input logic [RW-1:0] y,
                                   input logic pair);
    if (pair) return x[RW-1:1] == y[RW-1:1];
    return x == y;
  endfunction

  logic [DEPTH-1:0] hit;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      assign hit[e] = ent_v[e] &
                      (overlap(ent_dst[e], src_a, ent_dp[e] | rd_dp) |
                       overlap(ent_dst[e], src_b, ent_dp[e] | rd_dp));
    end
  endgenerate

  assign hazard = |hit;

endmodule

// File: rtl/fpco_rob.sv
module fpco_rob #(
  parameter int DEPTH = 4,
  parameter int RW    = 5,
  parameter int DW    = 64,
  parameter int NUNIT = 4,
  parameter int TW    = 2,
  parameter int CW    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc,
  input  logic [RW-1:0]            alloc_dst,
  input  logic                     alloc_dp,
  output logic [TW-1:0]            tail_tag,
  output logic                     full,
  input  logic [NUNIT-1:0]         cmp_v,
  input  logic [NUNIT-1:0][TW-1:0] cmp_tag,
  input  logic [NUNIT-1:0][DW-1:0] cmp_data,
  output logic [DEPTH-1:0]         ent_v,
  output logic [DEPTH-1:0]         ent_dp,
  output logic [DEPTH-1:0][RW-1:0] ent_dst,
  output logic [CW-1:0]            count,
  output logic                     wb_valid,
  output logic [RW-1:0]            wb_dst,
  output logic                     wb_dp,
  output logic [DW-1:0]            wb_data
);

  localparam int SPW = DW / 2;
  localparam logic [DW-1:0] SP_MASK = {{(DW-SPW){1'b0}}, {SPW{1'b1}}};

  logic [DEPTH-1:0] done_q;
  logic [DW-1:0]    data_q [DEPTH];
  logic [TW-1:0]    head_q, tail_q;
  logic             retire;

  function automatic logic [TW-1:0] step_ptr(input logic [TW-1:0] p);
    if (p == TW'(DEPTH - 1)) return '0;
    return p + TW'(1);
  endfunction

  assign retire   = ent_v[head_q] & done_q[head_q];
  assign full     = (count == CW'(DEPTH));
  assign tail_tag = tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v    <= '0;
      done_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      count    <= '0;
      wb_valid <= 1'b0;
      wb_dst   <= '0;
      wb_dp    <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= retire;
      if (retire) begin
        wb_dst        <= ent_dst[head_q];
        wb_dp         <= ent_dp[head_q];
        wb_data       <= ent_dp[head_q] ? data_q[head_q] : (data_q[head_q] & SP_MASK);
        ent_v[head_q] <= 1'b0;
        head_q        <= step_ptr(head_q);
      end
      for (int u = 0; u < NUNIT; u++) begin
        if (cmp_v[u]) done_q[cmp_tag[u]] <= 1'b1;
      end
      if (alloc) begin
        ent_v[tail_q]  <= 1'b1;
        done_q[tail_q] <= 1'b0;
        tail_q         <= step_ptr(tail_q);
      end
      count <= count + CW'(alloc) - CW'(retire);
    end
  end

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUNIT; u++) begin
      if (cmp_v[u]) data_q[cmp_tag[u]] <= cmp_data[u];
    end
    if (alloc) begin
      ent_dst[tail_q] <= alloc_dst;
      ent_dp[tail_q]  <= alloc_dp;
    end
  end

endmodule

// File: rtl/fpco_issue_ctrl.sv
module fpco_issue_ctrl #(
  parameter int NREG     = 32,
  parameter int DEPTH    = 4,
  parameter int NSP      = 2,
  parameter int NDP      = 2,
  parameter int LAT_STEP = 2,
  parameter int DW       = 64,
  localparam int RW      = $clog2(NREG),
  localparam int NUNIT   = NSP + NDP,
  localparam int UW      = $clog2(NUNIT),
  localparam int TW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [UW-1:0]       iss_unit,
  input  logic [RW-1:0]       iss_dst,
  input  logic [RW-1:0]       iss_src_a,
  input  logic [RW-1:0]       iss_src_b,
  output logic [NUNIT-1:0]    disp_valid,
  output logic [RW-1:0]       disp_src_a,
  output logic [RW-1:0]       disp_src_b,
  input  logic [NUNIT-1:0]    res_valid,
  input  logic [NUNIT*DW-1:0] res_data,
  output logic                wb_valid,
  output logic [RW-1:0]       wb_dst,
  output logic                wb_dp,
  output logic [DW-1:0]       wb_data
);
  import fpco_pkg::*;

  // Read stage
  logic          rd_valid;
  logic [UW-1:0] rd_unit;
  logic [RW-1:0] rd_dst, rd_a, rd_b;
  logic          rd_dp, rd_go, hazard, rob_full;

  // Execute entry and tracking
  logic [TW-1:0]            disp_tag, tail_tag;
  logic [NUNIT-1:0]         line_v;
  logic [NUNIT-1:0][TW-1:0] line_tag;
  logic [NUNIT-1:0][DW-1:0] res_words;
  logic [DEPTH-1:0]         ent_v, ent_dp;
  logic [DEPTH-1:0][RW-1:0] ent_dst;
  logic [CW-1:0]            count;

  assign rd_dp     = (unit_grp(int'(rd_unit), NSP) == GRP_DP);
  assign rd_go     = rd_valid & ~hazard & ~rob_full;
  assign iss_ready = ~rst & (~rd_valid | rd_go);
  assign res_words = res_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else if (iss_valid && iss_ready) begin
      rd_valid <= 1'b1;
    end else if (rd_go) begin
      rd_valid <= 1'b0;
    end
    if (iss_valid && iss_ready) begin
      rd_unit <= iss_unit;
      rd_dst  <= iss_dst;
      rd_a    <= iss_src_a;
      rd_b    <= iss_src_b;
    end
  end

  // First execute stage: registered dispatch
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= '0;
    end else begin
      disp_valid <= '0;
      if (rd_go) disp_valid[rd_unit] <= 1'b1;
    end
    disp_src_a <= rd_a;
    disp_src_b <= rd_b;
    disp_tag   <= tail_tag;
  end

  fpco_hazard #(.DEPTH(DEPTH), .RW(RW)) u_hazard (
    .ent_v  (ent_v),
    .ent_dp (ent_dp),
    .ent_dst(ent_dst),
    .src_a  (rd_a),
    .src_b  (rd_b),
    .rd_dp  (rd_dp),
    .hazard (hazard)
  );

  generate
    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
      fpco_lat_line #(.LAT(unit_lat(u, NSP, LAT_STEP)), .TW(TW)) u_line (
        .clk    (clk),
        .rst    (rst),
        .in_v   (disp_valid[u]),
        .in_tag (disp_tag),
        .out_v  (line_v[u]),
        .out_tag(line_tag[u])
      );
    end
  endgenerate

  fpco_rob #(.DEPTH(DEPTH), .RW(RW), .DW(DW), .NUNIT(NUNIT), .TW(TW), .CW(CW)) u_rob (
    .clk      (clk),
    .rst      (rst),
    .alloc    (rd_go),
    .alloc_dst(rd_dst),
    .alloc_dp (rd_dp),
    .tail_tag (tail_tag),
    .full     (rob_full),
    .cmp_v    (line_v),
    .cmp_tag  (line_tag),
    .cmp_data (res_words),
    .ent_v    (ent_v),
    .ent_dp   (ent_dp),
    .ent_dst  (ent_dst),
    .count    (count),
    .wb_valid (wb_valid),
    .wb_dst   (wb_dst),
    .wb_dp    (wb_dp),
    .wb_data  (wb_data)
  );

endmodule

// File: rtl/fpco_issue_ctrl_chk.sv
module fpco_issue_ctrl_chk #(
  parameter int NUNIT = 4,
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int RW    = 5,
  parameter int UW    = 2,
  parameter int DW    = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_ready,
  input logic [NUNIT-1:0] disp_valid,
  input logic [NUNIT-1:0] res_valid,
  input logic [NUNIT-1:0] line_v,
  input logic [CW-1:0]    count,
  input logic             rd_valid,
  input logic             rd_go,
  input logic [RW-1:0]    rd_dst,
  input logic [UW-1:0]    rd_unit,
  input logic             wb_valid,
  input logic             wb_dp,
  input logic [DW-1:0]    wb_data
);

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> iss_ready);

  p_stall_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_go) |=> (rd_valid && $stable(rd_dst) && $stable(rd_unit)));

  p_one_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(disp_valid));

  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid == line_v);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_full_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |=> (disp_valid == '0));

  p_sp_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_dp) |-> (wb_data[DW-1:DW/2] == '0));

endmodule

bind fpco_issue_ctrl fpco_issue_ctrl_chk #(
  .NUNIT(NUNIT), .DEPTH(DEPTH), .CW(CW), .RW(RW), .UW(UW), .DW(DW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_ready (iss_ready),
  .disp_valid(disp_valid),
  .res_valid (res_valid),
  .line_v    (line_v),
  .count     (count),
  .rd_valid  (rd_valid),
  .rd_go     (rd_go),
  .rd_dst    (rd_dst),
  .rd_unit   (rd_unit),
  .wb_valid  (wb_valid),
  .wb_dp     (wb_dp),
  .wb_data   (wb_data)
);

// File: tb/fpco_issue_ctrl_test.sv
`timescale 1ns/1ps
module fpco_issue_ctrl_test;

  localparam int NU = 4;
  localparam int LATS [NU] = '{1, 3, 2, 4};
  localparam int NLOG = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [1:0] iss_unit = '0;
  logic [4:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic [NU-1:0] disp_valid;
  logic [4:0] disp_src_a, disp_src_b;
  logic [NU-1:0] res_valid = '0;
  logic [NU*64-1:0] res_data = '0;
  logic wb_valid, wb_dp;
  logic [4:0] wb_dst;
  logic [63:0] wb_data;

  always #10 clk = ~clk;

  fpco_issue_ctrl uut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_unit(iss_unit),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .disp_valid(disp_valid), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
    .res_valid(res_valid), .res_data(res_data),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_dp(wb_dp), .wb_data(wb_data)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  int iss_n = 0, disp_n = 0, wb_n = 0;
  int acc_cyc [NLOG], disp_cyc [NLOG], wb_cyc [NLOG];
  logic [4:0]  exp_dst  [NLOG];
  logic        exp_dp   [NLOG];
  logic [63:0] exp_data [NLOG];

  // unit model slots
  logic        slot_v [NU][16];
  logic [63:0] slot_d [NU][16];

  // {exp_dp, unit, dst, src_a, src_b}
  localparam logic [17:0] VEC [12] = '{
    {1'b0, 2'd1, 5'd5,  5'd1,  5'd2},
    {1'b0, 2'd0, 5'd6,  5'd5,  5'd3},
    {1'b1, 2'd3, 5'd8,  5'd6,  5'd0},
    {1'b1, 2'd2, 5'd10, 5'd9,  5'd1},
    {1'b0, 2'd0, 5'd12, 5'd2,  5'd3},
    {1'b0, 2'd1, 5'd13, 5'd4,  5'd4},
    {1'b1, 2'd3, 5'd14, 5'd12, 5'd13},
    {1'b0, 2'd0, 5'd16, 5'd0,  5'd1},
    {1'b1, 2'd2, 5'd18, 5'd16, 5'd7},
    {1'b0, 2'd1, 5'd20, 5'd19, 5'd2},
    {1'b0, 2'd0, 5'd21, 5'd20, 5'd21},
    {1'b1, 2'd3, 5'd22, 5'd30, 5'd31}
  };

  function automatic logic [63:0] unit_word(input int u, input logic [4:0] a, input logic [4:0] b);
    return {8'(u), 3'b0, a, 3'b0, b, 8'h3C, 8'(u) ^ 8'h5A, 3'b0, a, 3'b0, b, 8'hC3};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    for (int u = 0; u < NU; u++)
      for (int s = 0; s < 16; s++) slot_v[u][s] = 1'b0;
  end

  // monitor and unit model, at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int u = 0; u < NU; u++) begin
      res_valid[u] = slot_v[u][cyc % 16];
      res_data[u*64 +: 64] = slot_d[u][cyc % 16];
      slot_v[u][cyc % 16] = 1'b0;
    end
    if (!rst && disp_valid != '0) begin
      for (int u = 0; u < NU; u++) begin
        if (disp_valid[u]) begin
          slot_v[u][(cyc + LATS[u]) % 16] = 1'b1;
          slot_d[u][(cyc + LATS[u]) % 16] = unit_word(u, disp_src_a, disp_src_b);
        end
      end
      if (disp_n < NLOG) disp_cyc[disp_n] = cyc;
      disp_n++;
    end
    if (!rst && wb_valid) begin
      if (wb_n >= iss_n) begin
        check(1'b0, "R7 unexpected write-back", wb_dst, 0);
      end else begin
        // R7: order by destination; R9: flag and data
        check(wb_dst == exp_dst[wb_n], "R7 order/dst", wb_dst, exp_dst[wb_n]);
        check(wb_dp == exp_dp[wb_n] && wb_data == exp_data[wb_n], "R9 data/dp",
              wb_data, exp_data[wb_n]);
        wb_cyc[wb_n] = cyc;
      end
      wb_n++;
    end
  end

  task automatic issue(input int u, input int d, input int a, input int b, input bit dp);
    logic [63:0] w;
    @(negedge clk);
    iss_valid = 1'b1;
    iss_unit  = 2'(u);
    iss_dst   = 5'(d);
    iss_src_a = 5'(a);
    iss_src_b = 5'(b);
    w = unit_word(u, 5'(a), 5'(b));
    exp_dst[iss_n]  = 5'(d);
    exp_dp[iss_n]   = dp;
    exp_data[iss_n] = dp ? w : {32'h0, w[31:0]};
    forever begin
      #1;
      if (iss_ready) begin
        acc_cyc[iss_n] = cyc;
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 iss_valid = 1'b0;
    iss_n++;
  endtask

  task automatic drain;
    while (wb_n < iss_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d write-backs", wb_n, iss_n);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(disp_valid == '0, "R1 no dispatch in reset", disp_valid, 0);
    check(wb_valid == 1'b0, "R1 no write-back in reset", wb_valid, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(iss_ready == 1'b1, "R1 ready after reset", iss_ready, 1);
    check(disp_valid == '0 && wb_valid == 1'b0, "R1 idle after reset", {disp_valid, wb_valid}, 0);

    // R10 / R3 / R4: isolated instruction on each unit
    for (int u = 0; u < NU; u++) begin
      k = iss_n;
      issue(u, 10 + u, 1, 2, u >= 2);
      drain();
      check(disp_cyc[k] == acc_cyc[k] + 2, "R3 dispatch timing", disp_cyc[k] - acc_cyc[k], 2);
      check(wb_cyc[k] == disp_cyc[k] + LATS[u] + 2, "R10 R4 write-back latency",
            wb_cyc[k] - disp_cyc[k], LATS[u] + 2);
    end

    // R2: independent back-to-back
    k = iss_n;
    issue(0, 3, 1, 2, 1'b0);
    issue(0, 4, 5, 6, 1'b0);
    drain();
    check(disp_cyc[k+1] == disp_cyc[k] + 1, "R2 back-to-back", disp_cyc[k+1] - disp_cyc[k], 1);

    // R5: RAW stall until producer written back
    k = iss_n;
    issue(3, 4, 1, 2, 1'b1);
    issue(0, 9, 4, 5, 1'b0);
    drain();
    check(disp_cyc[k+1] == wb_cyc[k] + 1, "R5 raw stall", disp_cyc[k+1] - wb_cyc[k], 1);

    // R6: double-precision writer pair 6/7, single reader of 7
    k = iss_n;
    issue(2, 6, 1, 2, 1'b1);
    issue(0, 9, 7, 1, 1'b0);
    drain();
    check(disp_cyc[k+1] == wb_cyc[k] + 1, "R6 pair stall", disp_cyc[k+1] - wb_cyc[k], 1);

    // R6: reader of 8 does not overlap pair 6/7
    k = iss_n;
    issue(2, 6, 1, 2, 1'b1);
    issue(0, 9, 8, 1, 1'b0);
    drain();
    check(disp_cyc[k+1] == disp_cyc[k] + 1, "R6 no pair overlap", disp_cyc[k+1] - disp_cyc[k], 1);

    // R6: single writer 13, double reader of pair 12/13
    k = iss_n;
    issue(1, 13, 1, 2, 1'b0);
    issue(3, 20, 12, 0, 1'b1);
    drain();
    check(disp_cyc[k+1] == wb_cyc[k] + 1, "R6 dp reader stall", disp_cyc[k+1] - wb_cyc[k], 1);

    // R7: younger short op finishes first, retires after older
    k = iss_n;
    issue(3, 20, 1, 2, 1'b1);
    issue(0, 21, 3, 4, 1'b0);
    drain();
    check(wb_cyc[k+1] == wb_cyc[k] + 1, "R7 held result follows", wb_cyc[k+1] - wb_cyc[k], 1);

    // R8: occupancy limit
    k = iss_n;
    for (int i = 0; i < 5; i++) issue(3, 16 + i, 0, 1, 1'b1);
    drain();
    check(disp_cyc[k+3] == disp_cyc[k] + 3, "R8 four in flight", disp_cyc[k+3] - disp_cyc[k], 3);
    check(disp_cyc[k+4] == disp_cyc[k] + 7, "R8 fifth waits", disp_cyc[k+4] - disp_cyc[k], 7);

    // table walk: mixed units with hazards; scoreboard checks R7 and R9
    for (int i = 0; i < 12; i++) begin
      issue(int'(VEC[i][16:15]), int'(VEC[i][14:10]), int'(VEC[i][9:5]), int'(VEC[i][4:0]),
            VEC[i][17]);
    end
    drain();
    check(wb_n == iss_n, "R7 all retired", wb_n, iss_n);
    check(disp_n == iss_n, "R3 all dispatched", disp_n, iss_n);

    // R1: reset flushes in-flight work
    issue(3, 25, 1, 2, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    k = wb_n;
    repeat (10) @(negedge clk);
    check(wb_n == k && disp_valid == '0, "R1 flush", wb_n - k, 0);
    check(iss_ready == 1'b1, "R1 ready after second reset", iss_ready, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule